// File: doc/BRIEF.md
# Multiplier-free pipelined second-order recursive filter section

This block is a second-order recursive (biquad) filter section whose five coefficients are fixed when the design is elaborated. None of them needs a multiplier. Each coefficient is written as the sum of three signed powers of two. Every product is therefore formed from three shifted copies of the operand, each optionally negated, added together. The section accepts one signed sample on every clock and delivers one signed result on every clock, with input and output at the same word length.

Inside the section, each input sample is scaled up by a number of fraction bits and widened by guard bits. The arithmetic then wraps in that internal width. The output is the integer part of the internal result, taken back to the word length with no rounding and no saturation.

Registers in the forward path let the clock rate rise without changing the response. The forward path has four stages: input capture, products, forward sum and output. The recursive loop closes within one cycle, so it is identical to the unpipelined equation. A higher level can chain several sections by wiring the output of one to the input of the next.

Top module: `csd_biquad_section`

## Requirements
- R1: While the active-high asynchronous reset `rst` is asserted, `y_out` is zero. Reset clears every delay and pipeline register, so after release with zero input the output stays zero.
- R2: A sample taken at rising edge k first affects `y_out` just after rising edge k+3. Nothing changes the output earlier.
- R3: The internal value follows v[n] = B0·s[n] + B1·s[n-1] + B2·s[n-2] + A1·v[n-1] + A2·v[n-2], evaluated modulo 2^IW. Here s[n] = x[n]·2^FB and IW = W+FB+GUARD. The feedback products are added, not subtracted.
- R4: A coefficient is a struct of three signed exponents e0, e1, e2 and a three-bit vector `neg`. Bit i of `neg` belongs to exponent ei. It is 1 when the term 2^ei is subtracted and 0 when it is added. With the default coefficients (B0 = 2^-3 − 2^-5 + 2^-7), an input of 256 after reset gives a first output of 26.
- R5: A negative exponent is an arithmetic right shift of the operand, which rounds toward minus infinity. A non-negative exponent is a left shift.
- R6: No result saturates. Every internal sum wraps modulo 2^IW, and the output field wraps modulo 2^W.
- R7: `y_out` equals bits [FB+W-1:FB] of the internal value v, which is the floor of v/2^FB taken modulo 2^W.
- R8: A new sample is accepted on every clock and a new result appears on every clock, with no stall.
- R9: A reset asserted in the middle of a stream discards all history. Zero input afterwards gives a zero output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Asynchronous reset, active high |
| x_in | input | W | Signed input sample, one per clock |
| y_out | output | W | Signed filtered output, one per clock |

## Verification
A sample placed on `x_in` before rising edge k is due on `y_out` right after edge k+3, which is three edges after it is captured. The first three edges after reset must leave the output at zero.

The bench drives each input half a period before the edge that captures it. It reads `y_out` half a period after every edge and compares it with the reference result for the sample captured three edges earlier. Before that point it expects zero.

Impulse, negative impulse, moderate step and overflowing step all run through this one aligned comparison. The first impulse output is also compared against a value worked out by hand.

// File: rtl/csd_biquad_pkg.sv
package csd_biquad_pkg;

  // Three signed power-of-two digits; neg[i] set means digit i (exponent ei) is subtracted.
  typedef struct packed {
    logic signed [7:0] e2;
    logic signed [7:0] e1;
    logic signed [7:0] e0;
    logic [2:0]        neg;
  } csd_coef_t;

  localparam int DIGITS = 3;

endpackage

// File: rtl/csd_const_mult.sv
module csd_const_mult
  import csd_biquad_pkg::*;
#(
  parameter int        IW = 32,
  parameter csd_coef_t C  = '0
) (
  input  logic signed [IW-1:0] v,
  output logic signed [IW-1:0] p
);

  localparam int EXP [DIGITS] = '{int'(C.e0), int'(C.e1), int'(C.e2)};

  // Power-of-two scaling: pure wiring, arithmetic for right shifts (R5).
  function automatic logic signed [IW-1:0] pow2_shift(input logic signed [IW-1:0] a,
                                                     input int e);
    if (e >= 0) return a <<< e;
    else        return a >>> (-e);
  endfunction

  logic signed [IW-1:0] term [DIGITS];

  for (genvar g = 0; g < DIGITS; g++) begin : g_digit
    assign term[g] = C.neg[g] ? -pow2_shift(v, EXP[g]) : pow2_shift(v, EXP[g]);
  end

  // Two adders per coefficient; sums wrap in IW bits (R6).
  assign p = term[0] + term[1] + term[2];

endmodule

// File: rtl/csd_biquad_ff.sv
module csd_biquad_ff
  import csd_biquad_pkg::*;
#(
  parameter int        W  = 16,
  parameter int        FB = 8,
  parameter int        IW = 32,
  parameter csd_coef_t B0 = '0,
  parameter csd_coef_t B1 = '0,
  parameter csd_coef_t B2 = '0
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic signed [W-1:0]  x_in,
  output logic signed [IW-1:0] ff_q
);

  // Sign-extend to the internal width and move into the fractional grid.
  function automatic logic signed [IW-1:0] scale_in(input logic signed [W-1:0] a);
    logic signed [IW-1:0] wide;
    wide = {{(IW-W){a[W-1]}}, a};
    return wide <<< FB;
  endfunction

  logic signed [IW-1:0] x_r, x_d1, x_d2;   // capture stage and z^-1 taps
  logic signed [IW-1:0] m0, m1, m2;        // combinational products
  logic signed [IW-1:0] p0, p1, p2;        // product pipeline stage

  csd_const_mult #(.IW(IW), .C(B0)) i_mul_b0 (.v(x_r),  .p(m0));
  csd_const_mult #(.IW(IW), .C(B1)) i_mul_b1 (.v(x_d1), .p(m1));
  csd_const_mult #(.IW(IW), .C(B2)) i_mul_b2 (.v(x_d2), .p(m2));

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      x_r  <= '0;
      x_d1 <= '0;
      x_d2 <= '0;
      p0   <= '0;
      p1   <= '0;
      p2   <= '0;
      ff_q <= '0;
    end else begin
      x_r  <= scale_in(x_in);
      x_d1 <= x_r;
      x_d2 <= x_d1;
      p0   <= m0;
      p1   <= m1;
      p2   <= m2;
      ff_q <= p0 + p1 + p2;
    end
  end

  // R3: an all-zero tap line yields a zero forward sum two stages later.
  a_r3_zero_in_zero_ff: assert property (@(posedge clk) disable iff (rst)
    (x_r == '0 && x_d1 == '0 && x_d2 == '0) |-> ##2 (ff_q == '0));

endmodule

// File: rtl/csd_biquad_fb.sv
module csd_biquad_fb
  import csd_biquad_pkg::*;
#(
  parameter int        W  = 16,
  parameter int        FB = 8,
  parameter int        IW = 32,
  parameter csd_coef_t A1 = '0,
  parameter csd_coef_t A2 = '0
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic signed [IW-1:0] ff_q,
  output logic signed [W-1:0]  y_out
);

  logic signed [IW-1:0] s1, s2;      // transposed recursive state
  logic signed [IW-1:0] y_acc;       // current internal result
  logic signed [IW-1:0] fa1, fa2;    // feedback products
  logic signed [IW-1:0] y_r;         // output pipeline stage

  assign y_acc = ff_q + s1;

  csd_const_mult #(.IW(IW), .C(A1)) i_mul_a1 (.v(y_acc), .p(fa1));
  csd_const_mult #(.IW(IW), .C(A2)) i_mul_a2 (.v(y_acc), .p(fa2));

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      s1  <= '0;
      s2  <= '0;
      y_r <= '0;
    end else begin
      s1  <= s2 + fa1;
      s2  <= fa2;
      y_r <= y_acc;
    end
  end

  // R7: integer part of the internal value, truncated to W bits.
  assign y_out = y_r[FB+W-1:FB];

  // R3: a quiet loop with a zero forward sum stays quiet.
  a_r3_rest_holds: assert property (@(posedge clk) disable iff (rst)
    (ff_q == '0 && s1 == '0 && s2 == '0) |=> (s1 == '0 && s2 == '0));

  // R9: with no history and no forward input the next output is zero.
  a_r9_loop_quiet: assert property (@(posedge clk) disable iff (rst)
    (ff_q == '0 && s1 == '0 && s2 == '0) |=> (y_out == '0));

endmodule

// File: rtl/csd_biquad_section.sv
module csd_biquad_section
  import csd_biquad_pkg::*;
#(
  parameter int        W     = 16,
  parameter int        FB    = 8,
  parameter int        GUARD = 8,
  // B0 = +2^-3 -2^-5 +2^-7
  parameter csd_coef_t B0 = '{e0: -8'sd3, e1: -8'sd5, e2: -8'sd7, neg: 3'b010},
  // B1 = +2^-2 -2^-4 -2^-6
  parameter csd_coef_t B1 = '{e0: -8'sd2, e1: -8'sd4, e2: -8'sd6, neg: 3'b110},
  // B2 = B0
  parameter csd_coef_t B2 = '{e0: -8'sd3, e1: -8'sd5, e2: -8'sd7, neg: 3'b010},
  // A1 = +2^0 +2^-1 -2^-3
  parameter csd_coef_t A1 = '{e0: 8'sd0, e1: -8'sd1, e2: -8'sd3, neg: 3'b100},
  // A2 = -2^-1 -2^-3 +2^-4
  parameter csd_coef_t A2 = '{e0: -8'sd1, e1: -8'sd3, e2: -8'sd4, neg: 3'b011}
) (
  input  logic                clk,
  input  logic                rst,
  input  logic signed [W-1:0] x_in,
  output logic signed [W-1:0] y_out
);

  localparam int IW = W + FB + GUARD;

  logic signed [IW-1:0] ff_q;

  csd_biquad_ff #(.W(W), .FB(FB), .IW(IW), .B0(B0), .B1(B1), .B2(B2)) i_ff (
    .clk  (clk),
    .rst  (rst),
    .x_in (x_in),
    .ff_q (ff_q)
  );

  csd_biquad_fb #(.W(W), .FB(FB), .IW(IW), .A1(A1), .A2(A2)) i_fb (
    .clk   (clk),
    .rst   (rst),
    .ff_q  (ff_q),
    .y_out (y_out)
  );

  // Edges seen since reset release, saturating; brought out for the latency check.
  logic [2:0] since_rst;
  always_ff @(posedge clk or posedge rst) begin
    if (rst)                 since_rst <= '0;
    else if (since_rst != 3'd7) since_rst <= since_rst + 3'd1;
  end

  // R2: no sample can reach the output before the fourth edge after reset.
  a_r2_min_latency: assert property (@(posedge clk) disable iff (rst)
    (since_rst < 3'd4) |-> (y_out == '0));

endmodule

// File: tb/test_csd_biquad_section.sv
module test_csd_biquad_section;

  localparam int BW  = 16;
  localparam int BFB = 8;
  localparam int BIW = 32;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic signed [BW-1:0] x_in = '0;
  logic signed [BW-1:0] y_out;

  always #2 clk = ~clk;   // 250 MHz

  csd_biquad_section i_csd_biquad_section (
    .clk(clk), .rst(rst), .x_in(x_in), .y_out(y_out)
  );

  // Coefficients restated as exponent/sign lists: b0, b1, b2, a1, a2.
  int ex [5][3] = '{'{-3, -5, -7}, '{-2, -4, -6}, '{-3, -5, -7}, '{0, -1, -3}, '{-1, -3, -4}};
  bit sb [5][3] = '{'{0, 1, 0},    '{0, 1, 1},    '{0, 1, 0},    '{0, 0, 1},   '{1, 1, 0}};

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  longint yexp [$];
  longint hx1 = 0, hx2 = 0, hv1 = 0, hv2 = 0;

  function automatic longint wrap_n(longint v, int n);
    longint m;
    m = v & ((64'sd1 <<< n) - 1);
    if (m >= (64'sd1 <<< (n - 1))) m = m - (64'sd1 <<< n);
    return m;
  endfunction

  function automatic longint floor_p2(longint v, int k);
    longint d, q;
    d = 64'sd1 <<< k;
    q = v / d;
    if (v < 0 && q * d != v) q = q - 1;
    return q;
  endfunction

  function automatic longint coef_mul(longint v, int idx);
    longint s, t;
    s = 0;
    for (int i = 0; i < 3; i++) begin
      if (ex[idx][i] >= 0) t = v * (64'sd1 <<< ex[idx][i]);
      else                 t = floor_p2(v, -ex[idx][i]);
      if (sb[idx][i]) t = -t;
      s = s + t;
    end
    return wrap_n(s, BIW);
  endfunction

  function automatic void model_push(int xv);
    longint xs, fwd, v;
    xs  = wrap_n(longint'(xv) * 256, BIW);
    fwd = wrap_n(coef_mul(xs, 0) + coef_mul(hx1, 1) + coef_mul(hx2, 2), BIW);
    v   = wrap_n(fwd + coef_mul(hv1, 3) + coef_mul(hv2, 4), BIW);
    hx2 = hx1; hx1 = xs;
    hv2 = hv1; hv1 = v;
    yexp.push_back(wrap_n(floor_p2(v, BFB), BW));
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s at cycle %0d: y_out=%0d expected=%0d", req, cyc, act, expv);
    end
  endtask

  // Drive one sample, wait for its capture edge, compare output three edges behind.
  task automatic step(input int xv, input string req);
    longint e;
    x_in = 16'(xv);
    model_push(xv);
    @(posedge clk);
    @(negedge clk);
    e = (cyc >= 3) ? yexp[cyc-3] : 0;
    chk(longint'(y_out) == e, req, longint'(y_out), e);
    cyc++;
  endtask

  task automatic do_reset(input string req);
    @(negedge clk);
    rst = 1'b1;
    x_in = '0;
    @(posedge clk);
    @(negedge clk);
    chk(y_out == '0, req, longint'(y_out), 0);
    rst = 1'b0;
    hx1 = 0; hx2 = 0; hv1 = 0; hv2 = 0;
    yexp.delete();
    cyc = 0;
  endtask

  initial begin
    #(4 * 200000);
    failures++;
    $display("FAIL watchdog: run did not complete");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    @(negedge clk);
    chk(y_out == '0, "R1 reset state", longint'(y_out), 0);
    do_reset("R1 held in reset");
    for (int i = 0; i < 6; i++) step(0, "R1 idle after reset");

    // Impulse: R2 latency, R4 digit signs, R3 recursion.
    do_reset("R1");
    for (int i = 0; i < 45; i++) begin
      step((i == 0) ? 256 : 0, (i < 3) ? "R2 before latency" : "R3 impulse response");
      if (i == 3) chk(y_out == 16'sd26, "R4 first impulse output", longint'(y_out), 26);
    end

    // Negative impulse: R5 floor behaviour of right shifts.
    do_reset("R1");
    step(-1, "R5 negative impulse");
    for (int i = 0; i < 30; i++) step(0, "R5 negative impulse tail");

    // Moderate step: R8 continuous flow and R7 truncation.
    do_reset("R1");
    for (int i = 0; i < 60; i++) step(5000, "R8 step every clock");
    for (int i = 0; i < 20; i++) step(-3 * i + 7, "R7 ramp truncation");

    // Large step: output field wraps (R6).
    do_reset("R1");
    for (int i = 0; i < 40; i++) step(30000, "R6 wrap on large step");

    // Mid-stream reset: R9 history discarded.
    for (int i = 0; i < 10; i++) step(-12000, "R6 wrap negative step");
    do_reset("R9 reset mid stream");
    for (int i = 0; i < 12; i++) step(0, "R9 no history after reset");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule